// File: doc/BRIEF.md
# PHY Register Access Bridge

This block sits between a host processor and the configuration port of an SD/eMMC PHY. Software sees one 32-bit control and status word. It places a 6-bit PHY register address and an 8-bit write value in that word, then sets a write strobe or a read strobe. The bridge turns the strobe into a request toward the PHY. It holds that request until the PHY acknowledges. It then raises an acknowledge flag in the word and, for a read, places the returned byte in the word.

Each transfer is a four-phase exchange. Software raises a strobe and polls until the acknowledge flag is set. It then lowers the strobe and leaves address and data as they were. The bridge clears the flag after it sees the strobe low, and only then accepts a new strobe. On the PHY side the request is a level signal. The PHY pulses `phy_ack` for one cycle to finish it. This is a plain control handshake with no data queue, so it has no further back-pressure rule. The PHY can stall a transfer for as long as it needs by withholding `phy_ack`.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset the word reads all zeros and neither PHY request is asserted.
- R2: The word layout is: address in bits 5:0, write data in bits 15:8, returned read data in bits 23:16, write strobe at bit 24, read strobe at bit 25 and acknowledge flag at bit 26. Bits 7:6 and 31:27 read as zero. Bus writes to bits 26, 23:16, 7:6 and 31:27 have no effect.
- R3: When a strobe is visible in the word and the acknowledge flag is low, a PHY request is raised on the next clock. It carries the address and data captured at that edge. Bus writes made while the request is open do not change `phy_addr` or `phy_wdata`.
- R4: A PHY request stays asserted until a clock edge at which `phy_ack` is high. It is deasserted on that edge, and the acknowledge flag is set on the same edge.
- R5: For a read, the value on `phy_rdata` at the acknowledging edge appears in bits 23:16. Bus writes and later write transfers leave that field unchanged until the next read completes.
- R6: The acknowledge flag clears on the clock after both strobes are seen low. Address and write data keep their values.
- R7: While the acknowledge flag is high, no new PHY request is started, even if a strobe stays high or is raised again. A strobe that is still high once the flag clears starts a new request.
- R8: A word with both strobes set produces a write request only. The read data field is not updated.
- R9: `phy_wr_req` and `phy_rd_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Value written to the control word |
| bus_rdata | output | 32 | Current control and status word |
| phy_addr | output | 6 | Captured PHY register address |
| phy_wdata | output | 8 | Captured PHY write value |
| phy_wr_req | output | 1 | Write request to the PHY, held until acknowledged |
| phy_rd_req | output | 1 | Read request to the PHY, held until acknowledged |
| phy_ack | input | 1 | One-cycle acknowledge from the PHY |
| phy_rdata | input | 8 | PHY read value, valid while `phy_ack` is high |

## Verification
A wrong transfer state shows up as one of three symptoms. A request may drop before `phy_ack`, or stay up after it. The acknowledge flag may rise without a PHY acknowledge, or fall while a strobe is still high. A second request may start while the flag is set. Each of these appears on `phy_wr_req`, `phy_rd_req` or bit 26 of `bus_rdata` within one clock of the faulty edge, so the reference model flags it in that cycle. A bad capture register shows up immediately on `phy_addr` and `phy_wdata`, or on the read data field once a read completes.

// File: rtl/phybr_pkg.sv
package phybr_pkg;
  // Field positions in the control word; software decodes these.
  localparam int unsigned ADDR_LSB  = 0;
  localparam int unsigned WDATA_LSB = 8;
  localparam int unsigned RDATA_LSB = 16;
  localparam int unsigned WSTB_BIT  = 24;
  localparam int unsigned RSTB_BIT  = 25;
  localparam int unsigned ACK_BIT   = 26;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_DONE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/phybr_ctrl_word.sv
module phybr_ctrl_word
  import phybr_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [ADDR_W-1:0] sw_addr,
  output logic [DATA_W-1:0] sw_wdata,
  output logic              sw_wr_stb,
  output logic              sw_rd_stb
);
  // Only software-owned fields are stored here; other bits are dropped.
  logic unused_ro_bits;
  assign unused_ro_bits = ^{bus_wdata[WORD_W-1:ACK_BIT],
                            bus_wdata[RDATA_LSB +: DATA_W],
                            bus_wdata[WDATA_LSB-1:ADDR_LSB+ADDR_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_addr   <= '0;
      sw_wdata  <= '0;
      sw_wr_stb <= 1'b0;
      sw_rd_stb <= 1'b0;
    end else if (bus_we) begin
      sw_addr   <= bus_wdata[ADDR_LSB +: ADDR_W];
      sw_wdata  <= bus_wdata[WDATA_LSB +: DATA_W];
      sw_wr_stb <= bus_wdata[WSTB_BIT];
      sw_rd_stb <= bus_wdata[RSTB_BIT];
    end
  end
endmodule

// File: rtl/phybr_xfer_fsm.sv
module phybr_xfer_fsm
  import phybr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_wr_stb,
  input  logic              sw_rd_stb,
  output logic              ack_flag,
  output logic [DATA_W-1:0] rd_hold,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_wr_req,
  output logic              phy_rd_req,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata
);
  xfer_state_e state_q;
  logic        is_write_q;
  logic        any_stb;

  assign any_stb = sw_wr_stb | sw_rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= XS_IDLE;
      is_write_q <= 1'b0;
      ack_flag   <= 1'b0;
      rd_hold    <= '0;
      phy_addr   <= '0;
      phy_wdata  <= '0;
    end else begin
      unique case (state_q)
        XS_IDLE: if (any_stb) begin
          phy_addr   <= sw_addr;
          phy_wdata  <= sw_wdata;
          is_write_q <= sw_wr_stb;       // write wins when both are set
          state_q    <= XS_REQ;
        end
        XS_REQ: if (phy_ack) begin
          ack_flag <= 1'b1;
          if (!is_write_q) rd_hold <= phy_rdata;
          state_q  <= XS_DONE;
        end
        XS_DONE: if (!any_stb) begin
          ack_flag <= 1'b0;
          state_q  <= XS_IDLE;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign phy_wr_req = (state_q == XS_REQ) &&  is_write_q;
  assign phy_rd_req = (state_q == XS_REQ) && !is_write_q;

  // R4: an open request and its fields hold until the PHY acknowledges
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_wr_req || phy_rd_req) && !phy_ack) |=>
      ((phy_wr_req || phy_rd_req) && $stable(phy_addr) && $stable(phy_wdata)));

  // R4: acknowledge closes the request and sets the flag on the same edge
  p_req_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phy_wr_req || phy_rd_req) && phy_ack) |=> (!phy_wr_req && !phy_rd_req && ack_flag));

  // R6: flag falls only after both strobes were seen low
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_flag) |-> $past(!sw_wr_stb && !sw_rd_stb));

  // R7: no request while the flag is up
  p_no_req_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_flag |-> (!phy_wr_req && !phy_rd_req));

  // R5: held read data changes only on an acknowledged read
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_hold) |-> $past(phy_rd_req && phy_ack));

  // R3: a request starts only from a visible strobe with the flag low
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_wr_req || phy_rd_req) |-> $past((sw_wr_stb || sw_rd_stb) && !ack_flag));
endmodule

// File: rtl/phybr_word_pack.sv
module phybr_word_pack
  import phybr_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_wr_stb,
  input  logic              sw_rd_stb,
  input  logic              ack_flag,
  input  logic [DATA_W-1:0] rd_hold,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    word[ADDR_LSB  +: ADDR_W] = sw_addr;
    word[WDATA_LSB +: DATA_W] = sw_wdata;
    word[RDATA_LSB +: DATA_W] = rd_hold;
    word[WSTB_BIT]            = sw_wr_stb;
    word[RSTB_BIT]            = sw_rd_stb;
    word[ACK_BIT]             = ack_flag;
  end
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_wr_req,
  output logic              phy_rd_req,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata
);
  logic [ADDR_W-1:0] sw_addr;
  logic [DATA_W-1:0] sw_wdata;
  logic              sw_wr_stb;
  logic              sw_rd_stb;
  logic              ack_flag;
  logic [DATA_W-1:0] rd_hold;

  phybr_ctrl_word #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_word (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_wr_stb(sw_wr_stb), .sw_rd_stb(sw_rd_stb)
  );

  phybr_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_wr_stb(sw_wr_stb), .sw_rd_stb(sw_rd_stb),
    .ack_flag(ack_flag), .rd_hold(rd_hold),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_wr_req(phy_wr_req), .phy_rd_req(phy_rd_req),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  phybr_word_pack #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pack (
    .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_wr_stb(sw_wr_stb), .sw_rd_stb(sw_rd_stb),
    .ack_flag(ack_flag), .rd_hold(rd_hold), .word(bus_rdata)
  );

  // R9: the two request lines are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_wr_req && phy_rd_req));
endmodule

// File: tb/phy_reg_bridge_tb.sv
module phy_reg_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  phy_addr;
  logic [7:0]  phy_wdata;
  logic        phy_wr_req, phy_rd_req;
  logic        phy_ack = 1'b0;
  logic [7:0]  phy_rdata = 8'h00;

  phy_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_wr_req(phy_wr_req), .phy_rd_req(phy_rd_req),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int         m_st = 0;  // 0 idle, 1 request open, 2 waiting for strobe low
  bit         m_kw, m_wr, m_rd, m_ack;
  logic [5:0] m_addr, m_ca;
  logic [7:0] m_wd, m_cd, m_rdat;

  // PHY register file model
  logic [7:0] mem [64];
  int wcnt = 0, lat = 1, nxfer = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {5'd0, m_ack, m_rd, m_wr, m_rdat, m_wd, 2'd0, m_addr};
  endfunction

  task automatic tick();
    bit p_rst = rst_n, p_we = bus_we, p_ack = phy_ack;
    logic [31:0] p_wd = bus_wdata;
    logic [7:0]  p_rd = phy_rdata;
    @(posedge clk);
    #1;
    if (!p_rst) begin
      m_st = 0; m_kw = 0; m_wr = 0; m_rd = 0; m_ack = 0;
      m_addr = 0; m_ca = 0; m_wd = 0; m_cd = 0; m_rdat = 0;
    end else begin
      if (m_st == 0) begin
        if (m_wr || m_rd) begin m_st = 1; m_kw = m_wr; m_ca = m_addr; m_cd = m_wd; end
      end else if (m_st == 1) begin
        if (p_ack) begin m_st = 2; m_ack = 1; if (!m_kw) m_rdat = p_rd; end
      end else begin
        if (!m_wr && !m_rd) begin m_st = 0; m_ack = 0; end
      end
      if (p_we) begin
        m_addr = p_wd[5:0]; m_wd = p_wd[15:8]; m_wr = p_wd[24]; m_rd = p_wd[25];
      end
    end
    check(bus_rdata === exp_word(), "R2 R5 R6 R7 word", bus_rdata, exp_word());
    check(phy_wr_req === (m_st == 1 && m_kw), "R4 R8 wr_req", 32'(phy_wr_req), 32'(m_st == 1 && m_kw));
    check(phy_rd_req === (m_st == 1 && !m_kw), "R4 R7 rd_req", 32'(phy_rd_req), 32'(m_st == 1 && !m_kw));
    check(phy_addr === m_ca && phy_wdata === m_cd, "R3 captured fields",
          {18'd0, phy_addr, phy_wdata}, {18'd0, m_ca, m_cd});
    check(!(phy_wr_req && phy_rd_req), "R9 exclusive", {30'd0, phy_wr_req, phy_rd_req}, 32'd0);
    // PHY responder
    if (phy_ack) begin
      phy_ack = 0;
      phy_rdata = 8'(8'h5A ^ nxfer);
    end else if (phy_wr_req || phy_rd_req) begin
      if (wcnt >= lat) begin
        phy_ack = 1;
        phy_rdata = mem[phy_addr];
        if (phy_wr_req) mem[phy_addr] = phy_wdata;
        wcnt = 0; nxfer++; lat = (nxfer * 3) % 4;
      end else wcnt++;
    end
  endtask

  task automatic bus_write(input logic [31:0] w);
    bus_we = 1; bus_wdata = w;
    tick();
    bus_we = 0;
  endtask

  task automatic wait_ack(input bit v, input string tag);
    int n = 0;
    while (bus_rdata[26] !== v && n < 40) begin tick(); n++; end
    check(bus_rdata[26] === v, tag, 32'(bus_rdata[26]), 32'(v));
  endtask

  task automatic xfer(input logic [5:0] a, input logic [7:0] d, input bit wr, input bit rd);
    logic [31:0] base = {16'd0, d, 2'd0, a};
    bus_write(base);
    bus_write(base | {6'd0, rd, wr, 24'd0});
    wait_ack(1, "R4 ack set");
    bus_write(base);
    wait_ack(0, "R6 ack clear");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 1);
    repeat (3) tick();
    #2 rst_n = 1;
    tick();
    // R1 reset state
    check(bus_rdata === 32'd0, "R1 reset word", bus_rdata, 32'd0);
    check(!phy_wr_req && !phy_rd_req, "R1 no request", {30'd0, phy_wr_req, phy_rd_req}, 32'd0);

    // R2 read-only and reserved bits ignored
    bus_write(32'hF8FF_C0C0 & ~32'h0300_0000);
    check(bus_rdata === 32'h0000_C000, "R2 ignored bits", bus_rdata, 32'h0000_C000);

    // basic write then read back
    xfer(6'd5, 8'hA5, 1, 0);
    xfer(6'd5, 8'h00, 0, 1);
    check(bus_rdata[23:16] === 8'hA5, "R5 read data", 32'(bus_rdata[23:16]), 32'hA5);

    // R5 write transfer leaves read data alone
    xfer(6'd63, 8'h11, 1, 0);
    check(bus_rdata[23:16] === 8'hA5, "R5 held over write", 32'(bus_rdata[23:16]), 32'hA5);

    // R8 both strobes -> write
    xfer(6'd9, 8'h3C, 1, 1);
    check(mem[9] === 8'h3C, "R8 write performed", 32'(mem[9]), 32'h3C);
    check(bus_rdata[23:16] === 8'hA5, "R8 read field kept", 32'(bus_rdata[23:16]), 32'hA5);
    xfer(6'd9, 8'h00, 0, 1);
    check(bus_rdata[23:16] === 8'h3C, "R8 read back", 32'(bus_rdata[23:16]), 32'h3C);

    // R3 bus rewrite during an open request: long latency forced
    lat = 3; wcnt = 0;
    bus_write({16'd0, 8'h77, 2'd0, 6'd20});
    bus_write({16'd0, 8'h77, 2'd0, 6'd20} | 32'h0100_0000);
    tick();
    bus_write(32'h0100_9915);
    wait_ack(1, "R4 ack after rewrite");
    check(mem[20] === 8'h77, "R3 captured write", 32'(mem[20]), 32'h77);
    // R7 swap strobe while ack high: no new request
    bus_write(32'h0200_9915);
    repeat (3) tick();
    check(!phy_wr_req && !phy_rd_req && bus_rdata[26], "R7 no restart",
          {29'd0, bus_rdata[26], phy_wr_req, phy_rd_req}, 32'd4);
    // R7 drop then raise immediately while ack still set
    bus_write(32'h0000_9915);
    bus_write(32'h0200_9915);
    wait_ack(0, "R7 ack cleared");
    wait_ack(1, "R7 pending served");
    check(bus_rdata[23:16] === mem[21], "R7 pending read", 32'(bus_rdata[23:16]), 32'(mem[21]));
    bus_write(32'h0000_9915);
    wait_ack(0, "R6 final clear");
    check(bus_rdata[15:0] === 16'h9915, "R6 fields kept", 32'(bus_rdata[15:0]), 32'h9915);

    // sweep
    for (int k = 0; k < 12; k++) begin
      xfer(6'(k * 5), 8'(k * 19 + 3), 1, 0);
      xfer(6'(k * 5), 8'h00, 0, 1);
      check(bus_rdata[23:16] === 8'(k * 19 + 3), "R5 sweep", 32'(bus_rdata[23:16]), 32'(8'(k * 19 + 3)));
    end
    repeat (3) tick();
    finish_run();
  end
endmodule